// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

This block turns pairs of 16-bit two's-complement samples into one serial bit stream. Each sample period carries a left half and then a right half. The block can be the clock master: it divides the system clock down to a bit clock, a left/right clock and a word strobe, all of which it drives out. It can also be a slave: it follows a bit clock, a left/right clock and a word strobe that come from outside, and lines its data up with them. Data changes on the falling edge of the bit clock, and the receiver samples it on the rising edge. Every half frame is a channel slot. After its last data bit, the data line stays low until the end of that slot.

Three mode pins pick one of eight formats. One pin selects master or slave, and the other two pick the data alignment. In master mode the four alignments are left-aligned, one-slot-delayed, right-aligned with a framing strobe, and right-aligned with a single-slot strobe pulse. In slave mode the fourth alignment is replaced by a strobe-triggered format: the data starts one slot after the external strobe is first seen high. The pins are captured only while reset is asserted.

Samples arrive on a valid/ready port that holds a single entry. `s_ready` is high whenever that entry is empty. A pair moves across when `s_valid` and `s_ready` are both high at a clock edge. The producer must hold `s_valid` and the data until that edge. The entry empties only when a left slot starts and the held pair is taken for transmission. If no new pair has arrived by then, the previous pair is sent again.

Top module: `stereo_ser_tx`

## Requirements
- R1: While reset is asserted, `sdata_o`=0, `frame_o`=0 and `s_ready`=1. In master mode `sclk_o`=1 and `lrclk_o`=1; in slave mode both are 0.
- R2: In master mode, `sclk_o` has a period of 2*DIV clk cycles. A falling edge opens each bit slot. `lrclk_o` changes only together with a falling edge of `sclk_o`: it is 0 for the 32 slots of the left half and 1 for the 32 slots of the right half. The first falling edge after reset opens slot 1 of a left half.
- R3: `sdata_o` changes only when a bit slot opens. Each word is sent MSB first, one bit per slot, with 16 bits in consecutive slots.
- R4: The left word is sent while the left/right clock is 0 and the right word while it is 1. The pair in use is replaced only when a left half opens.
- R5: Mode {cfg_rjust,cfg_delay}=00 (left-aligned): data sits in slots 1..16, and in master mode `frame_o` is 1 in slots 1..16.
- R6: Mode 01 (one-slot delay): data sits in slots 2..17, and in master mode `frame_o` is 1 in slots 2..17.
- R7: Mode 10 (right-aligned): data sits in slots 17..32, and in master mode `frame_o` is 1 in slots 17..32.
- R8: Master mode 11 (pulsed right-aligned): data sits in slots 17..32, and `frame_o` is 1 in slot 17 only.
- R9: In every slot that holds no data bit, `sdata_o` is 0.
- R10: `s_ready` = 1 exactly when the single holding entry is empty. If no pair is held when a left half opens, the previous pair is sent again.
- R11: Slave mode (`cfg_slave`=1) counts slots from the falling edges of `sclk_i`. A falling edge at which `lrclk_i` differs from its previous value opens slot 1 of the half that `lrclk_i` selects (0 = left). Data follows R5..R7, and `sclk_o`, `lrclk_o` and `frame_o` stay 0.
- R12: Slave mode 11: `frame_i` is sampled on rising edges of `sclk_i`. The first sample that is high after a change of `lrclk_i` makes the MSB start in the next slot. Later high samples in the same half are ignored, so `frame_i` tied high gives the data placement of mode 01.
- R13: The mode pins are captured only while reset is asserted. Changing them later has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low; mode pins captured while low |
| cfg_slave | input | 1 | 1 = slave (external clocks), 0 = master |
| cfg_rjust | input | 1 | Alignment select, upper bit |
| cfg_delay | input | 1 | Alignment select, lower bit |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Holding entry empty |
| s_left | input | DATA_W | Left sample, two's complement |
| s_right | input | DATA_W | Right sample, two's complement |
| sclk_i | input | 1 | External bit clock (slave) |
| lrclk_i | input | 1 | External left/right clock (slave) |
| frame_i | input | 1 | External word strobe (slave) |
| sclk_o | output | 1 | Bit clock (master) |
| lrclk_o | output | 1 | Left/right clock (master) |
| frame_o | output | 1 | Word strobe (master) |
| sdata_o | output | 1 | Serial data |

## Verification
In master mode, `sclk_o`, `lrclk_o`, `frame_o` and `sdata_o` all change on the same clk edge, and the bench samples at each rising edge of `sclk_o`, half a bit after the data changed. A handshake takes effect at the next clk edge: the bench records the accepted pair one clk later, after it has applied any left-half latch made at that same edge. It then compares `s_ready` against its own queue on every clk. In slave mode, `sdata_o` follows an external falling edge after no more than SYNC+2 clk cycles. The bench holds each phase of `sclk_i` for eight clk cycles and checks just before it drives each rising edge, so that the latency is well inside the sampling window.

// File: rtl/ssx_pkg.sv
package ssx_pkg;

  typedef enum logic [1:0] {
    FMT_LEFT  = 2'b00,
    FMT_I2S   = 2'b01,
    FMT_RIGHT = 2'b10,
    FMT_ALT   = 2'b11
  } fmt_e;

  typedef struct packed {
    logic slave;
    fmt_e fmt;
  } mode_t;

  // first slot carrying data for a fixed-placement format
  function automatic int first_slot(fmt_e f, int slots, int dw);
    case (f)
      FMT_LEFT: return 1;
      FMT_I2S:  return 2;
      default:  return slots - dw + 1;
    endcase
  endfunction

  // last slot with the master word strobe high
  function automatic int strobe_last(fmt_e f, int slots, int dw);
    case (f)
      FMT_LEFT:  return dw;
      FMT_I2S:   return dw + 1;
      FMT_RIGHT: return slots;
      default:   return slots - dw + 1;
    endcase
  endfunction

endpackage

// File: rtl/ssx_master_clk.sv
module ssx_master_clk #(
  parameter int DIV    = 2,
  parameter int SLOTS  = 32,
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  output logic              sclk,
  output logic              lrclk,
  output logic              ev_fall,
  output logic [SLOT_W-1:0] slot_nxt,
  output logic              lr_nxt
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0]     div_q;
  logic [SLOT_W-1:0] slot_q;
  logic              tick;
  logic              wrap;

  assign tick    = en && (div_q == DW'(DIV - 1));
  assign ev_fall = tick && sclk;

  always_comb begin
    wrap     = (slot_q == SLOT_W'(SLOTS));
    slot_nxt = wrap ? SLOT_W'(1) : slot_q + SLOT_W'(1);
    lr_nxt   = wrap ? ~lrclk : lrclk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sclk   <= 1'b1;
      lrclk  <= 1'b1;
      slot_q <= SLOT_W'(SLOTS);
    end else if (en) begin
      div_q <= tick ? '0 : div_q + DW'(1);
      if (tick) begin
        sclk <= ~sclk;
        if (sclk) begin
          slot_q <= slot_nxt;
          lrclk  <= lr_nxt;
        end
      end
    end
  end

  // R2
  lr_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lrclk) |-> $fell(sclk));

endmodule

// File: rtl/ssx_slave_trk.sv
module ssx_slave_trk #(
  parameter int SYNC   = 2,
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              lrclk_i,
  input  logic              frame_i,
  output logic              ev_fall,
  output logic [SLOT_W-1:0] slot_nxt,
  output logic              lr_nxt,
  output logic              trig
);
  localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

  logic [SYNC-1:0]   sc_s, lr_s, fr_s;
  logic              sc_d, lr_q, armed, pend;
  logic [SLOT_W-1:0] slot_q;
  logic              sc_now, fr_now, rise, lr_chg;

  assign sc_now  = sc_s[SYNC-1];
  assign fr_now  = fr_s[SYNC-1];
  assign lr_nxt  = lr_s[SYNC-1];
  assign ev_fall = sc_d && !sc_now;
  assign rise    = !sc_d && sc_now;
  assign lr_chg  = (lr_nxt != lr_q);
  assign trig    = pend && !lr_chg;

  always_comb begin
    if (lr_chg)                slot_nxt = SLOT_W'(1);
    else if (slot_q == SLOT_MAX) slot_nxt = SLOT_MAX;
    else                       slot_nxt = slot_q + SLOT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_s   <= '1;
      lr_s   <= '1;
      fr_s   <= '0;
      sc_d   <= 1'b1;
      lr_q   <= 1'b1;
      slot_q <= SLOT_MAX;
      armed  <= 1'b0;
      pend   <= 1'b0;
    end else begin
      sc_s <= {sc_s[SYNC-2:0], sclk_i};
      lr_s <= {lr_s[SYNC-2:0], lrclk_i};
      fr_s <= {fr_s[SYNC-2:0], frame_i};
      sc_d <= sc_now;
      if (ev_fall) begin
        lr_q   <= lr_nxt;
        slot_q <= slot_nxt;
        pend   <= 1'b0;
        if (lr_chg) armed <= 1'b1;
      end
      if (rise && armed && fr_now) begin
        pend  <= 1'b1;
        armed <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ssx_shifter.sv
module ssx_shifter
  import ssx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SLOTS  = 32,
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_t             mode,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_left,
  input  logic [DATA_W-1:0] s_right,
  output logic              s_ready,
  input  logic              ev_fall,
  input  logic [SLOT_W-1:0] slot_nxt,
  input  logic              lr_nxt,
  input  logic              trig,
  output logic              sdata
);
  localparam int CW = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] hold_l, hold_r, cur_l, cur_r, sh, word;
  logic [CW-1:0]     cnt;
  logic              full, latch, start;

  assign s_ready = !full;
  assign latch   = ev_fall && full && !lr_nxt && (slot_nxt == SLOT_W'(1));

  always_comb begin
    if (lr_nxt) word = latch ? hold_r : cur_r;
    else        word = latch ? hold_l : cur_l;
    if (mode.slave && mode.fmt == FMT_ALT)
      start = ev_fall && trig;
    else
      start = ev_fall && (slot_nxt == SLOT_W'(first_slot(mode.fmt, SLOTS, DATA_W)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l <= '0;
      hold_r <= '0;
      full   <= 1'b0;
      cur_l  <= '0;
      cur_r  <= '0;
      sh     <= '0;
      cnt    <= '0;
      sdata  <= 1'b0;
    end else begin
      if (s_valid && !full) begin
        hold_l <= s_left;
        hold_r <= s_right;
        full   <= 1'b1;
      end else if (latch) begin
        full <= 1'b0;
      end
      if (latch) begin
        cur_l <= hold_l;
        cur_r <= hold_r;
      end
      if (start) begin
        sdata <= word[DATA_W-1];
        sh    <= {word[DATA_W-2:0], 1'b0};
        cnt   <= CW'(DATA_W - 1);
      end else if (ev_fall) begin
        if (cnt != '0) begin
          sdata <= sh[DATA_W-1];
          sh    <= {sh[DATA_W-2:0], 1'b0};
          cnt   <= cnt - CW'(1);
        end else begin
          sdata <= 1'b0;
        end
      end
    end
  end

  // R10
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |=> !s_ready);

  // R4
  latch_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_l) |-> $past(ev_fall && !lr_nxt));

endmodule

// File: rtl/stereo_ser_tx.sv
module stereo_ser_tx
  import ssx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SLOTS  = 32,
  parameter int DIV    = 2,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_slave,
  input  logic              cfg_rjust,
  input  logic              cfg_delay,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_left,
  input  logic [DATA_W-1:0] s_right,
  input  logic              sclk_i,
  input  logic              lrclk_i,
  input  logic              frame_i,
  output logic              sclk_o,
  output logic              lrclk_o,
  output logic              frame_o,
  output logic              sdata_o
);
  localparam int SLOT_W = $clog2(SLOTS + 2);

  mode_t             mode_q;
  logic              m_sclk, m_lr, m_fall, m_lrn;
  logic [SLOT_W-1:0] m_slot;
  logic              x_fall, x_lrn, x_trig;
  logic [SLOT_W-1:0] x_slot;
  logic              ev_fall, lr_nxt, trig;
  logic [SLOT_W-1:0] slot_nxt;
  logic              frame_q, in_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '{slave: cfg_slave, fmt: fmt_e'({cfg_rjust, cfg_delay})};
  end

  ssx_master_clk #(.DIV(DIV), .SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_mclk (
    .clk(clk), .rst_n(rst_n), .en(!mode_q.slave),
    .sclk(m_sclk), .lrclk(m_lr), .ev_fall(m_fall), .slot_nxt(m_slot), .lr_nxt(m_lrn)
  );

  ssx_slave_trk #(.SYNC(SYNC), .SLOT_W(SLOT_W)) u_strk (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .lrclk_i(lrclk_i), .frame_i(frame_i),
    .ev_fall(x_fall), .slot_nxt(x_slot), .lr_nxt(x_lrn), .trig(x_trig)
  );

  always_comb begin
    if (mode_q.slave) begin
      ev_fall = x_fall; slot_nxt = x_slot; lr_nxt = x_lrn; trig = x_trig;
    end else begin
      ev_fall = m_fall; slot_nxt = m_slot; lr_nxt = m_lrn; trig = 1'b0;
    end
    in_win = (slot_nxt >= SLOT_W'(first_slot(mode_q.fmt, SLOTS, DATA_W))) &&
             (slot_nxt <= SLOT_W'(strobe_last(mode_q.fmt, SLOTS, DATA_W)));
  end

  ssx_shifter #(.DATA_W(DATA_W), .SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .mode(mode_q),
    .s_valid(s_valid), .s_left(s_left), .s_right(s_right), .s_ready(s_ready),
    .ev_fall(ev_fall), .slot_nxt(slot_nxt), .lr_nxt(lr_nxt), .trig(trig),
    .sdata(sdata_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        frame_q <= 1'b0;
    else if (!mode_q.slave && m_fall)  frame_q <= in_win;
  end

  assign sclk_o  = !mode_q.slave && m_sclk;
  assign lrclk_o = !mode_q.slave && m_lr;
  assign frame_o = frame_q;

  // R3
  data_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata_o) |-> $past(ev_fall));

  // R13
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mode_q));

endmodule

// File: tb/stereo_ser_tx_test.sv
module stereo_ser_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2;
  localparam int H = 8;

  logic clk = 0, rst_n = 0;
  logic cfg_slave = 0, cfg_rjust = 0, cfg_delay = 0;
  logic s_valid = 0, s_ready;
  logic [15:0] s_left = 0, s_right = 0;
  logic sclk_i = 1, lrclk_i = 1, frame_i = 0;
  logic sclk_o, lrclk_o, frame_o, sdata_o;

  int checks = 0, errors = 0;
  bit done = 0;

  stereo_ser_tx #(.DATA_W(16), .SLOTS(32), .DIV(DIV), .SYNC(2)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_slave(cfg_slave), .cfg_rjust(cfg_rjust),
    .cfg_delay(cfg_delay), .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left),
    .s_right(s_right), .sclk_i(sclk_i), .lrclk_i(lrclk_i), .frame_i(frame_i),
    .sclk_o(sclk_o), .lrclk_o(lrclk_o), .frame_o(frame_o), .sdata_o(sdata_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] gen(int i);
    case (i)
      0: return {16'h8000, 16'h7FFF};
      1: return {16'hFFFF, 16'h0001};
      default: return {16'(i * 16'h3B1D) ^ 16'h5A5A, ~16'(i * 16'h1234)};
    endcase
  endfunction

  function automatic logic ebit(int st, int s, logic [15:0] w);
    if (s >= st && s < st + 16) return w[15 - (s - st)];
    return 1'b0;
  endfunction

  function automatic int fstart(int fmt);
    case (fmt) 0: return 1; 1: return 2; default: return 17; endcase
  endfunction

  function automatic string ftag(int fmt);
    case (fmt) 0: return "R5"; 1: return "R6"; 2: return "R7"; default: return "R8"; endcase
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  // ---------------- master reference model ----------------
  bit mon_on = 0;
  int m_fmt, falls, cyc, m_slot, m_ch;
  logic prev_sclk;
  logic [31:0] q[$];
  logic [31:0] cur, acc_data;
  bit acc_pend;

  always @(negedge clk) begin
    if (mon_on) begin
      cyc++;
      if (prev_sclk && !sclk_o) begin
        falls++;
        if (falls > 1) chk(cyc == 2*DIV, "R2 sclk period", cyc, 2*DIV);
        cyc = 0;
        m_slot = ((falls - 1) % 32) + 1;
        m_ch = ((falls - 1) / 32) % 2;
        chk(lrclk_o == m_ch[0], "R2/R4 lrclk", lrclk_o, m_ch);
        if (m_slot == 1 && m_ch == 0 && q.size() > 0) cur = q.pop_front();
      end
      if (!prev_sclk && sclk_o && falls > 0) begin
        automatic logic [15:0] w = m_ch ? cur[15:0] : cur[31:16];
        automatic int st = fstart(m_fmt);
        automatic logic e = ebit(st, m_slot, w);
        automatic bit win = (m_slot >= st && m_slot < st + 16);
        automatic logic ef;
        case (m_fmt)
          0: ef = (m_slot >= 1 && m_slot <= 16);
          1: ef = (m_slot >= 2 && m_slot <= 17);
          2: ef = (m_slot >= 17);
          default: ef = (m_slot == 17);
        endcase
        chk(sdata_o == e, win ? (m_slot == st ? "R3 msb" : ftag(m_fmt)) : "R9 idle", sdata_o, e);
        chk(frame_o == ef, {ftag(m_fmt), " frame"}, frame_o, ef);
      end
      prev_sclk = sclk_o;
      if (acc_pend) q.push_back(acc_data);
      acc_pend = s_valid && s_ready;
      acc_data = {s_left, s_right};
      chk(s_ready == (q.size() == 0), "R10 ready", s_ready, q.size() == 0);
    end
  end

  task automatic do_reset(bit sl, int fmt);
    rst_n = 0;
    s_valid = 0;
    cfg_slave = sl; {cfg_rjust, cfg_delay} = fmt[1:0];
    sclk_i = 1; lrclk_i = 1; frame_i = 0;
    repeat (4) @(negedge clk);
    // R1
    chk(sdata_o == 0, "R1 sdata", sdata_o, 0);
    chk(frame_o == 0, "R1 frame", frame_o, 0);
    chk(s_ready == 1, "R1 ready", s_ready, 1);
    chk(sclk_o == !sl, "R1 sclk", sclk_o, !sl);
    chk(lrclk_o == !sl, "R1 lrclk", lrclk_o, !sl);
  endtask

  task automatic feed_master(int n);
    for (int i = 0; i < n; i++) begin
      step();
      s_valid = 1;
      {s_left, s_right} = gen(i);
      @(negedge clk);
      while (!s_ready) @(negedge clk);
      step();
      s_valid = 0;
      repeat (i == 2 ? 700 : 5 + i) step();
    end
  endtask

  task automatic run_master(int fmt);
    do_reset(0, fmt);
    step();
    rst_n = 1;
    m_fmt = fmt; falls = 0; cyc = 0; prev_sclk = 1; q.delete(); cur = 0; acc_pend = 0;
    mon_on = 1;
    fork
      feed_master(6);
      begin repeat (10 * 64 * 2 * DIV) step(); end
      begin
        repeat (300) step();
        // R13: pins change after reset; the model keeps the captured mode
        cfg_slave = 1; cfg_rjust = ~cfg_rjust; cfg_delay = ~cfg_delay;
      end
    join
    mon_on = 0;
  endtask

  // ---------------- slave stimulus and model ----------------
  task automatic run_slave(int fmt, int tlo, int thi, int frames);
    logic [31:0] scur, snext;
    bit have_next;
    int st;
    string tg;
    do_reset(1, fmt);
    step();
    rst_n = 1;
    step();
    s_valid = 1; {s_left, s_right} = gen(10);
    step();
    s_valid = 0;
    scur = 0; snext = gen(10); have_next = 1;
    st = (fmt == 3) ? tlo + 1 : fstart(fmt);
    tg = (fmt == 3) ? "R12" : "R11";
    repeat (4) step();
    for (int f = 0; f < frames; f++) begin
      for (int ch = 0; ch < 2; ch++) begin
        for (int s = 1; s <= 32; s++) begin
          bit offer;
          logic e;
          sclk_i = 0; lrclk_i = ch[0];
          frame_i = (fmt == 3) && (s >= tlo) && (s <= thi);
          if (ch == 0 && s == 1 && have_next) begin scur = snext; have_next = 0; end
          offer = (ch == 1 && s == 10 && f != 1);
          if (offer) begin s_valid = 1; {s_left, s_right} = gen(11 + f); end
          step();
          if (offer) begin s_valid = 0; snext = gen(11 + f); have_next = 1; end
          repeat (H - 2) step();
          e = ebit(st, s, ch ? scur[15:0] : scur[31:16]);
          chk(sdata_o == e, tg, sdata_o, e);
          chk({sclk_o, lrclk_o, frame_o} == 3'b000, "R11 idle outputs", {sclk_o, lrclk_o, frame_o}, 0);
          step();
          sclk_i = 1;
          repeat (H - 1) step();
        end
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int fm = 0; fm < 4; fm++) run_master(fm);  // R5 R6 R7 R8 R9 R10 R13
    run_slave(0, 0, 0, 3);    // R11 left-aligned
    run_slave(1, 0, 0, 3);    // R11 one-slot delay
    run_slave(2, 0, 0, 3);    // R11 right-aligned
    run_slave(3, 5, 7, 3);    // R12 first high sample in slot 5
    run_slave(3, 1, 32, 3);   // R12 tied high behaves like one-slot delay
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule